// File: doc/BRIEF.md
# Operand Barrel Shifter With Carry

This block forms the second operand of a 32-bit ALU together with the carry that a logical operation would place in the C flag. It is purely combinational: register reads and flag storage stay outside it, and the current C flag comes in as an input.

Two operand forms are supported. In the register form, a source word is shifted by one of four shift kinds. The amount is either a 5-bit field taken from the instruction or the low byte of a second register. In the constant form, an 8-bit constant is rotated right by twice a 4-bit rotate field. A zero amount has its own meaning in each case. For an instruction-field amount it means a plain pass for left shifts, a full-width shift for right shifts, and a one-bit rotate through carry for rotates. For a register amount it means a plain pass that keeps the incoming carry.

Top module: `opnd_shifter`

## Requirements
- R1: `shift_kind` encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. A logical left shift by 1 to 31 gives `src_val << n`, and its carry is source bit (32 - n).
- R2: A logical left shift by exactly 32 gives zero with carry equal to source bit 0. A logical left shift by more than 32 gives zero with carry 0.
- R3: A logical right shift by n from 1 to 32 gives `src_val >> n` with carry equal to source bit (n - 1). Above 32 it gives zero with carry 0. An instruction-field amount of 0 counts as 32.
- R4: An arithmetic right shift by n from 1 to 31 sign-fills and takes carry from source bit (n - 1). At 32 and above, every result bit and the carry equal source bit 31. An instruction-field amount of 0 counts as 32.
- R5: A nonzero rotate right turns the word by n mod 32. Its carry is source bit ((n mod 32) + 31) mod 32, so it equals result bit 31.
- R6: A rotate with an instruction-field amount of 0 rotates right by one through carry. The result is `{carry_in, src_val[31:1]}` and the carry is `src_val[0]`.
- R7: A register amount uses only bits 7:0 of `amt_reg`. When those bits are zero, the source passes unchanged and the carry equals `carry_in` for every shift kind.
- R8: A logical left shift with an instruction-field amount of 0 passes the source unchanged, and the carry equals `carry_in`.
- R9: When `form_imm` is 1, the result is the zero-extended `const_val` rotated right by 2 × `rot_field`. `shift_kind`, the amount inputs and `src_val` have no effect on the result.
- R10: In the constant form, the carry equals `carry_in` when `rot_field` is 0 and equals result bit 31 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| form_imm | input | 1 | 1 selects the rotated-constant form, 0 selects the shifted-register form |
| shift_kind | input | 2 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| amt_from_reg | input | 1 | 1 takes the amount from `amt_reg`, 0 takes it from `amt_imm` |
| amt_imm | input | 5 | Instruction-field shift amount |
| amt_reg | input | 32 | Register holding the amount (bits 7:0 used) |
| src_val | input | 32 | Word to be shifted |
| const_val | input | 8 | Constant for the rotated-constant form |
| rot_field | input | 4 | Rotate field; the rotation is twice this value |
| carry_in | input | 1 | Current C flag |
| opnd_out | output | 32 | Shifted or rotated operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Two corner rules can fall on the same input set. One is the reinterpretation of a zero amount (pass, shift by 32, or rotate through carry). The other is the rule that only the low byte of a register amount counts. A register value such as 0x100 sets off both at once: the amount is zero after truncation and must keep the old carry. A value such as 0x120 must act as a full 32-bit shift. The bench drives such words and, for all four shift kinds, judges the result and carry against a model that moves the word one bit per step and records the last bit that falls out. Long runs of random inputs add further collisions of the two rules.

// File: rtl/opnd_shift_pkg.sv
package opnd_shift_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/opnd_amt_decode.sv
module opnd_amt_decode
  import opnd_shift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 5,
  parameter int AMT_W   = 8
) (
  input  shift_kind_e        kind,
  input  logic               from_reg,
  input  logic [FIELD_W-1:0] field_amt,
  input  logic [DATA_W-1:0]  reg_amt,
  output logic [AMT_W-1:0]   amt,
  output logic               pass_thru,
  output logic               rrx
);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic [AMT_W-1:0] reg_low;
  logic             field_zero;

  assign reg_low    = reg_amt[AMT_W-1:0];
  assign field_zero = (field_amt == '0);

  always_comb begin
    pass_thru = 1'b0;
    rrx       = 1'b0;
    if (from_reg) begin
      amt       = reg_low;
      pass_thru = (reg_low == '0);
    end else if (field_zero) begin
      amt       = FULL_AMT;
      pass_thru = (kind == SK_LSL);
      rrx       = (kind == SK_ROR);
    end else begin
      amt = AMT_W'(field_amt);
    end
  end
endmodule

// File: rtl/opnd_reg_shift.sv
module opnd_reg_shift
  import opnd_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  shift_kind_e       kind,
  input  logic [DATA_W-1:0] src,
  input  logic [AMT_W-1:0]  amt,
  input  logic              pass_thru,
  input  logic              rrx,
  input  logic              cin,
  output logic [DATA_W-1:0] val,
  output logic              cout
);
  localparam int LOG_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  // each function returns {carry, value}
  function automatic logic [DATA_W:0] lsl_f(input logic [DATA_W-1:0] v,
                                            input logic [AMT_W-1:0] n);
    logic [DATA_W:0] t;
    t = {1'b0, v} << n;
    return t;
  endfunction

  function automatic logic [DATA_W:0] lsr_f(input logic [DATA_W-1:0] v,
                                            input logic [AMT_W-1:0] n);
    logic [DATA_W:0] t;
    t = {v, 1'b0} >> n;
    return {t[0], t[DATA_W:1]};
  endfunction

  function automatic logic [DATA_W:0] asr_f(input logic [DATA_W-1:0] v,
                                            input logic [AMT_W-1:0] n);
    logic signed [DATA_W:0] t;
    logic [AMT_W-1:0]       ns;
    ns = (n > FULL_AMT) ? FULL_AMT : n;
    t  = $signed({v, 1'b0});
    t  = t >>> ns;
    return {t[0], t[DATA_W:1]};
  endfunction

  function automatic logic [DATA_W:0] ror_f(input logic [DATA_W-1:0] v,
                                            input logic [LOG_W-1:0] r);
    logic [2*DATA_W-1:0] d;
    d = {v, v} >> r;
    return {d[DATA_W-1], d[DATA_W-1:0]};
  endfunction

  logic [DATA_W:0] res;

  always_comb begin
    if (pass_thru) begin
      res = {cin, src};
    end else if (rrx) begin
      res = {src[0], cin, src[DATA_W-1:1]};
    end else begin
      unique case (kind)
        SK_LSL:  res = lsl_f(src, amt);
        SK_LSR:  res = lsr_f(src, amt);
        SK_ASR:  res = asr_f(src, amt);
        default: res = ror_f(src, amt[LOG_W-1:0]);
      endcase
    end
  end

  assign cout = res[DATA_W];
  assign val  = res[DATA_W-1:0];
endmodule

// File: rtl/opnd_const_rot.sv
module opnd_const_rot #(
  parameter int DATA_W  = 32,
  parameter int CONST_W = 8,
  parameter int ROT_W   = 4
) (
  input  logic [CONST_W-1:0] cval,
  input  logic [ROT_W-1:0]   rot,
  input  logic               cin,
  output logic [DATA_W-1:0]  val,
  output logic               cout
);
  localparam int LOG_W = $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] rotr_f(input logic [DATA_W-1:0] v,
                                               input logic [LOG_W-1:0] r);
    logic [2*DATA_W-1:0] d;
    d = {v, v} >> r;
    return d[DATA_W-1:0];
  endfunction

  logic [LOG_W-1:0] rot_amt;

  assign rot_amt = LOG_W'({rot, 1'b0});
  assign val     = rotr_f(DATA_W'(cval), rot_amt);
  assign cout    = (rot == '0) ? cin : val[DATA_W-1];
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opnd_shift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 5,
  parameter int AMT_W   = 8,
  parameter int CONST_W = 8,
  parameter int ROT_W   = 4
) (
  input  logic               form_imm,
  input  logic [1:0]         shift_kind,
  input  logic               amt_from_reg,
  input  logic [FIELD_W-1:0] amt_imm,
  input  logic [DATA_W-1:0]  amt_reg,
  input  logic [DATA_W-1:0]  src_val,
  input  logic [CONST_W-1:0] const_val,
  input  logic [ROT_W-1:0]   rot_field,
  input  logic               carry_in,
  output logic [DATA_W-1:0]  opnd_out,
  output logic               carry_out
);
  shift_kind_e       kind;
  logic [AMT_W-1:0]  amt_eff;
  logic              zero_pass;
  logic              rrx_sel;
  logic [DATA_W-1:0] reg_val;
  logic              reg_c;
  logic [DATA_W-1:0] rot_val;
  logic              rot_c;

  assign kind = shift_kind_e'(shift_kind);

  opnd_amt_decode #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .AMT_W(AMT_W)) u_dec (
    .kind      (kind),
    .from_reg  (amt_from_reg),
    .field_amt (amt_imm),
    .reg_amt   (amt_reg),
    .amt       (amt_eff),
    .pass_thru (zero_pass),
    .rrx       (rrx_sel)
  );

  opnd_reg_shift #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_sh (
    .kind      (kind),
    .src       (src_val),
    .amt       (amt_eff),
    .pass_thru (zero_pass),
    .rrx       (rrx_sel),
    .cin       (carry_in),
    .val       (reg_val),
    .cout      (reg_c)
  );

  opnd_const_rot #(.DATA_W(DATA_W), .CONST_W(CONST_W), .ROT_W(ROT_W)) u_rot (
    .cval (const_val),
    .rot  (rot_field),
    .cin  (carry_in),
    .val  (rot_val),
    .cout (rot_c)
  );

  assign opnd_out  = form_imm ? rot_val : reg_val;
  assign carry_out = form_imm ? rot_c   : reg_c;
endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk #(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 5,
  parameter int AMT_W   = 8,
  parameter int CONST_W = 8,
  parameter int ROT_W   = 4
) (
  input logic               form_imm,
  input logic [1:0]         shift_kind,
  input logic               amt_from_reg,
  input logic [FIELD_W-1:0] amt_imm,
  input logic [DATA_W-1:0]  amt_reg,
  input logic [DATA_W-1:0]  src_val,
  input logic [CONST_W-1:0] const_val,
  input logic [ROT_W-1:0]   rot_field,
  input logic               carry_in,
  input logic [DATA_W-1:0]  opnd_out,
  input logic               carry_out,
  input logic               zero_pass,
  input logic               rrx_sel
);
  logic             known;
  logic [AMT_W-1:0] rlow;

  assign rlow  = amt_reg[AMT_W-1:0];
  assign known = !$isunknown({form_imm, shift_kind, amt_from_reg, amt_imm, amt_reg,
                              src_val, const_val, rot_field, carry_in});

  always_comb begin
    if (known && !form_imm && amt_from_reg && rlow == '0) begin
      // R7
      zero_reg_amt_chk: assert (opnd_out == src_val && carry_out == carry_in && zero_pass)
        else $error("zero register amount altered operand");
    end
    if (known && !form_imm && amt_from_reg && shift_kind == 2'd0 && rlow > AMT_W'(DATA_W)) begin
      // R2
      lsl_over_chk: assert (opnd_out == '0 && !carry_out)
        else $error("oversized left shift not cleared");
    end
    if (known && !form_imm && shift_kind == 2'd2 &&
        ((amt_from_reg && rlow >= AMT_W'(DATA_W)) || (!amt_from_reg && amt_imm == '0))) begin
      // R4
      asr_fill_chk: assert (opnd_out == {DATA_W{src_val[DATA_W-1]}} &&
                            carry_out == src_val[DATA_W-1])
        else $error("arithmetic saturation wrong");
    end
    if (known && !form_imm && !amt_from_reg && shift_kind == 2'd3 && amt_imm == '0) begin
      // R6
      rrx_chk: assert (rrx_sel && opnd_out[DATA_W-1] == carry_in && carry_out == src_val[0])
        else $error("rotate through carry wrong");
    end
    if (known && !form_imm && shift_kind == 2'd3 && !zero_pass && !rrx_sel) begin
      // R5
      ror_keep_chk: assert ($countones(opnd_out) == $countones(src_val) &&
                            carry_out == opnd_out[DATA_W-1])
        else $error("rotate lost bits or carry");
    end
    if (known && form_imm) begin
      // R10
      const_carry_chk: assert (carry_out == ((rot_field == '0) ? carry_in : opnd_out[DATA_W-1]))
        else $error("constant carry wrong");
      // R9
      const_bits_chk: assert ($countones(opnd_out) == $countones(const_val))
        else $error("constant rotate lost bits");
    end
  end
endmodule

bind opnd_shifter opnd_shifter_chk #(
  .DATA_W(DATA_W), .FIELD_W(FIELD_W), .AMT_W(AMT_W), .CONST_W(CONST_W), .ROT_W(ROT_W)
) u_chk (
  .form_imm     (form_imm),
  .shift_kind   (shift_kind),
  .amt_from_reg (amt_from_reg),
  .amt_imm      (amt_imm),
  .amt_reg      (amt_reg),
  .src_val      (src_val),
  .const_val    (const_val),
  .rot_field    (rot_field),
  .carry_in     (carry_in),
  .opnd_out     (opnd_out),
  .carry_out    (carry_out),
  .zero_pass    (zero_pass),
  .rrx_sel      (rrx_sel)
);

// File: tb/sim_opnd_shifter.sv
module sim_opnd_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        form_imm = 1'b0;
  logic [1:0]  shift_kind = '0;
  logic        amt_from_reg = 1'b0;
  logic [4:0]  amt_imm = '0;
  logic [31:0] amt_reg = '0;
  logic [31:0] src_val = '0;
  logic [7:0]  const_val = '0;
  logic [3:0]  rot_field = '0;
  logic        carry_in = 1'b0;
  logic [31:0] opnd_out;
  logic        carry_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  opnd_shifter u0 (
    .form_imm(form_imm), .shift_kind(shift_kind), .amt_from_reg(amt_from_reg),
    .amt_imm(amt_imm), .amt_reg(amt_reg), .src_val(src_val), .const_val(const_val),
    .rot_field(rot_field), .carry_in(carry_in), .opnd_out(opnd_out), .carry_out(carry_out)
  );

  // Behavioural model: move the word one bit per step, keep the last bit out.
  task automatic model(output logic [31:0] v, output logic c);
    int n;
    v = src_val;
    c = carry_in;
    if (form_imm) begin
      v = {24'd0, const_val};
      for (int i = 0; i < 2 * int'(rot_field); i++) v = {v[0], v[31:1]};
      if (rot_field != 0) c = v[31];
      return;
    end
    n = amt_from_reg ? int'(amt_reg[7:0]) : int'(amt_imm);
    if (n == 0 && !amt_from_reg) begin
      if (shift_kind == 2'd1 || shift_kind == 2'd2) n = 32;
      else if (shift_kind == 2'd3) begin
        c = src_val[0];
        v = {carry_in, src_val[31:1]};
        return;
      end
    end
    for (int i = 0; i < n; i++) begin
      case (shift_kind)
        2'd0: begin c = v[31]; v = v << 1; end
        2'd1: begin c = v[0];  v = v >> 1; end
        2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
  endtask

  function automatic string tag_of();
    int n;
    if (form_imm) return (rot_field == 0) ? "R10" : "R9";
    n = amt_from_reg ? int'(amt_reg[7:0]) : int'(amt_imm);
    if (amt_from_reg && n == 0) return "R7";
    case (shift_kind)
      2'd0: return (!amt_from_reg && n == 0) ? "R8" : (n >= 32 ? "R2" : "R1");
      2'd1: return "R3";
      2'd2: return "R4";
      default: return (!amt_from_reg && n == 0) ? "R6" : "R5";
    endcase
  endfunction

  task automatic check_now(input string tag);
    logic [31:0] ev;
    logic        ec;
    @(negedge clk);
    model(ev, ec);
    checks++;
    if (opnd_out !== ev || carry_out !== ec) begin
      fails++;
      $display("FAIL %s: got val=%h c=%b expected val=%h c=%b", tag, opnd_out, carry_out, ev, ec);
    end
  endtask

  task automatic do_reg(input logic [1:0] k, input logic fr, input logic [4:0] ai,
                        input logic [31:0] ar, input logic [31:0] s, input logic ci);
    @(posedge clk);
    #1;
    form_imm = 1'b0; shift_kind = k; amt_from_reg = fr; amt_imm = ai;
    amt_reg = ar; src_val = s; carry_in = ci;
    check_now(tag_of());
  endtask

  task automatic do_imm(input logic [7:0] cv, input logic [3:0] rf, input logic ci,
                        input logic [1:0] k, input logic [31:0] s);
    @(posedge clk);
    #1;
    form_imm = 1'b1; const_val = cv; rot_field = rf; carry_in = ci;
    shift_kind = k; src_val = s; amt_reg = s; amt_imm = s[4:0];
    check_now(tag_of());
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    check_now("R8");                                  // rest state: all-zero inputs
    do_reg(2'd0, 1'b0, 5'd4, '0, 32'hF000000F, 1'b0); // R1
    do_reg(2'd0, 1'b1, 5'd0, 32'd1, 32'h80000001, 1'b0);
    do_reg(2'd0, 1'b1, 5'd0, 32'hFFFFFF04, 32'h0000FFFF, 1'b1); // R7 low byte only
    do_reg(2'd0, 1'b1, 5'd0, 32'd32, 32'h00000001, 1'b0);       // R2
    do_reg(2'd0, 1'b1, 5'd0, 32'd33, 32'hFFFFFFFF, 1'b1);       // R2
    do_reg(2'd1, 1'b0, 5'd0, '0, 32'h80000000, 1'b0);           // R3 zero field = 32
    do_reg(2'd1, 1'b1, 5'd0, 32'd40, 32'hFFFFFFFF, 1'b1);       // R3
    do_reg(2'd1, 1'b0, 5'd1, '0, 32'h00000003, 1'b0);           // R3
    do_reg(2'd2, 1'b0, 5'd0, '0, 32'h80000000, 1'b0);           // R4
    do_reg(2'd2, 1'b1, 5'd0, 32'd200, 32'h7FFFFFFF, 1'b1);      // R4
    do_reg(2'd2, 1'b0, 5'd4, '0, 32'h80000010, 1'b1);           // R4
    do_reg(2'd3, 1'b0, 5'd8, '0, 32'h12345678, 1'b1);           // R5
    do_reg(2'd3, 1'b1, 5'd0, 32'd32, 32'h80000000, 1'b0);       // R5
    do_reg(2'd3, 1'b1, 5'd0, 32'd36, 32'h0000000F, 1'b0);       // R5
    do_reg(2'd3, 1'b0, 5'd0, '0, 32'h00000001, 1'b1);           // R6
    do_reg(2'd3, 1'b0, 5'd0, '0, 32'h00000002, 1'b0);           // R6
    for (int k = 0; k < 4; k++) begin
      do_reg(2'(k), 1'b1, 5'd0, 32'h00000100, 32'h80000001, 1'b1); // R7 truncated zero
      do_reg(2'(k), 1'b1, 5'd0, 32'h00000120, 32'h80000001, 1'b0); // R7 truncated 32
    end
    do_reg(2'd0, 1'b0, 5'd0, '0, 32'hDEADBEEF, 1'b1);           // R8
    do_imm(8'hFF, 4'd4, 1'b1, 2'd0, 32'h0);                     // R9
    do_imm(8'h80, 4'd0, 1'b1, 2'd2, 32'hFFFFFFFF);              // R10
    do_imm(8'h03, 4'd1, 1'b1, 2'd3, 32'h00000000);              // R9 R10
    do_imm(8'h01, 4'd15, 1'b1, 2'd1, 32'h12345678);             // R9
    do_imm(8'h5A, 4'd3, 1'b0, 2'd0, 32'h00000000);              // R9 other fields
    do_imm(8'h5A, 4'd3, 1'b0, 2'd3, 32'hFFFFFFFF);              // R9 other fields
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r1, r2;
      r1 = $urandom;
      r2 = $urandom;
      if (r1[31:29] == 3'd0)
        do_imm(r2[7:0], r2[11:8], r1[0], r1[2:1], r2);
      else
        do_reg(r1[2:1], r1[3], r1[8:4], {r2[31:9], r1[28], r1[15:9]}, r2, r1[0]);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule